// File: doc/BRIEF.md
# ECG Segment Signal-Quality Grader

This block watches a stream of signed ECG samples, each marked by a valid strobe, and cuts the stream into segments of a fixed number of accepted samples. For every segment it decides whether the lead carries any usable signal (flat line), whether the baseline moved abruptly, and whether the trace is dominated by high-frequency noise. The decisions rest on turning points: samples at which the slope of the trace reverses. The block counts them and measures how closely they follow one another.

After the final sample of a segment the block publishes the three flags, a quality index equal to their sum, and a three-level grade. A one-cycle done pulse marks the result. Downstream logic uses the grade to decide whether the segment is forwarded for analysis or transmission. The default parameters describe 11-bit samples covering a 10 mV span at 360 samples per second, with one-second segments.

Top module: `ecg_seg_quality`

## Requirements
- R1: `seg_done` is high for exactly one cycle, in the cycle after the clock edge that accepts the SEG_LEN-th valid sample of a segment. Cycles with `smp_vld` low change no state and produce no pulse.
- R2: A turning point is a sample whose nonzero first difference has the opposite sign to the most recent nonzero difference in the same segment. The first high-frequency rule holds when the segment's turning-point count times 100 exceeds HF_TP_PCT times SEG_LEN.
- R3: The second high-frequency rule holds when two successive turning points in the segment sit on adjacent samples (spacing below two). `flag_hfnoise` is 1 only when both rules hold and the segment is not flat.
- R4: `flag_absent` is 1 when the segment has no turning point, or when its maximum minus minimum sample is below FLAT_P2P. A flat segment always reports `flag_hfnoise` = 0.
- R5: The baseline is the floor of the mean of the last 2^AVG_LOG2 accepted samples, with zeros before reset release. The baseline runs across segment boundaries. `flag_wander` is 1 when the baseline's maximum minus minimum within the segment exceeds floor(ABW_UV * 2^W / FS_UV) codes (40 codes at the defaults).
- R6: `sqi` equals `flag_absent + flag_wander + flag_hfnoise`, a value from 0 to 3.
- R7: `grade` is encoded as 2'b00 good, 2'b01 intermediate and 2'b10 bad, and never 2'b11. A flat or wandering segment is bad. Otherwise, a noisy segment compares A*10000 against E times a threshold. Here A is the largest absolute difference seen at an adjacent-turning-point sample, and E is the larger of |max| and |min|. The segment is bad when A*10000 > BAD_BP*E, intermediate when A*10000 > INT_BP*E, and good otherwise. A segment without noise is good.
- R8: All outputs are registered and hold their values between done pulses. A synchronous active-low reset clears every output, counter and baseline tap to zero.
- R9: Turning-point detection starts afresh in each segment. The first sample of a segment only seeds the slope history, so a slope reversal across a segment boundary is not a turning point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_vld | input | 1 | Sample strobe |
| smp_data | input | W | Signed sample in ADC codes |
| seg_done | output | 1 | One-cycle result pulse |
| flag_absent | output | 1 | Flat line / no signal |
| flag_wander | output | 1 | Abrupt baseline movement |
| flag_hfnoise | output | 1 | High-frequency noise |
| sqi | output | 2 | Sum of the three flags |
| grade | output | 2 | 00 good, 01 intermediate, 10 bad |

## Verification
Several conditions are hard to reach from the ports because the baseline average carries history across segment boundaries. Landing a noisy segment in the intermediate band, or in the good band while it is still flagged noisy, also needs a settled baseline. The stimulus therefore sends each pattern twice: the first copy fills the averaging window, and the second copy produces a segment whose baseline is steady. Zig-zag amplitudes are picked around a large offset so that the ratio of step to extreme falls in each band. A rising ramp followed by a falling ramp places a slope reversal exactly on a segment boundary, which tests R9.

// File: rtl/ecg_sq_pkg.sv
// Shared types for the segment quality grader.
package ecg_sq_pkg;
    // Three-level quality grade; 2'b11 is never produced.
    typedef enum logic [1:0] {
        GRADE_GOOD = 2'b00,
        GRADE_MID  = 2'b01,
        GRADE_BAD  = 2'b10
    } grade_e;
endpackage

// File: rtl/ecg_tp_track.sv
// Turning-point tracker for one segment.
// Counts slope reversals and records whether two reversals landed on
// adjacent samples. It also keeps the largest step magnitude seen at such a
// close pair.
// Assumes: 'first' is high with the first valid sample of each segment;
// the *_nxt outputs already include the sample presented on x this cycle.
module ecg_tp_track #(
    parameter int W       = 11,
    parameter int SEG_LEN = 360,
    localparam int CW     = $clog2(SEG_LEN + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vld,
    input  logic                first,
    input  logic signed [W-1:0] x,
    output logic [CW-1:0]       tp_cnt_nxt,
    output logic                short_nxt,
    output logic [W:0]          amp_nxt
);
    logic signed [W-1:0] prev_x, prev_x_nxt;
    logic                have_sgn, have_sgn_nxt;
    logic                sgn_up, sgn_up_nxt;
    logic [CW-1:0]       tp_cnt;
    logic                have_tp, have_tp_nxt;
    logic [CW-1:0]       gap, gap_nxt;
    logic                short_seen;
    logic [W:0]          amp;

    logic signed [W:0]   diff;
    logic [W:0]          mag;
    logic                nz, up, is_tp;

    // Slope, reversal detection and next-state for the segment statistics.
    always_comb begin
        diff  = {x[W-1], x} - {prev_x[W-1], prev_x};
        nz    = (diff != '0);
        up    = !diff[W];
        mag   = diff[W] ? (W+1)'(-diff) : (W+1)'(diff);
        is_tp = have_sgn && nz && (up != sgn_up);

        prev_x_nxt   = x;
        have_sgn_nxt = have_sgn;
        sgn_up_nxt   = sgn_up;
        tp_cnt_nxt   = tp_cnt;
        have_tp_nxt  = have_tp;
        gap_nxt      = gap;
        short_nxt    = short_seen;
        amp_nxt      = amp;
        if (first) begin
            have_sgn_nxt = 1'b0;
            sgn_up_nxt   = 1'b0;
            tp_cnt_nxt   = '0;
            have_tp_nxt  = 1'b0;
            gap_nxt      = '0;
            short_nxt    = 1'b0;
            amp_nxt      = '0;
        end else begin
            if (nz) begin
                have_sgn_nxt = 1'b1;
                sgn_up_nxt   = up;
            end
            if (is_tp) begin
                tp_cnt_nxt  = tp_cnt + 1'b1;
                have_tp_nxt = 1'b1;
                gap_nxt     = '0;
                if (have_tp && (gap == '0)) begin
                    short_nxt = 1'b1;
                    if (mag > amp) amp_nxt = mag;
                end
            end else if (gap != '1) begin
                gap_nxt = gap + 1'b1;
            end
        end
    end

    // State update on each accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_x     <= '0;
            have_sgn   <= 1'b0;
            sgn_up     <= 1'b0;
            tp_cnt     <= '0;
            have_tp    <= 1'b0;
            gap        <= '0;
            short_seen <= 1'b0;
            amp        <= '0;
        end else if (vld) begin
            prev_x     <= prev_x_nxt;
            have_sgn   <= have_sgn_nxt;
            sgn_up     <= sgn_up_nxt;
            tp_cnt     <= tp_cnt_nxt;
            have_tp    <= have_tp_nxt;
            gap        <= gap_nxt;
            short_seen <= short_nxt;
            amp        <= amp_nxt;
        end
    end

    AST_TP_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        tp_cnt < CW'(SEG_LEN)); // R2
    AST_SHORT_NEEDS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        short_seen |-> (tp_cnt >= CW'(2))); // R3
    AST_AMP_NEEDS_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (amp != '0) |-> short_seen); // R7
endmodule

// File: rtl/ecg_amp_span.sv
// Per-segment extreme tracker: running maximum and minimum of the raw
// samples. Assumes 'first' marks the first valid sample of a segment; the
// *_nxt outputs include the sample presented this cycle.
module ecg_amp_span #(
    parameter int W = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vld,
    input  logic                first,
    input  logic signed [W-1:0] x,
    output logic signed [W-1:0] max_nxt,
    output logic signed [W-1:0] min_nxt
);
    logic signed [W-1:0] seg_max, seg_min;

    // Extremes including the current sample, restarting on 'first'.
    always_comb begin
        if (first) begin
            max_nxt = x;
            min_nxt = x;
        end else begin
            max_nxt = (x > seg_max) ? x : seg_max;
            min_nxt = (x < seg_min) ? x : seg_min;
        end
    end

    // Register the extremes on accepted samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_max <= '0;
            seg_min <= '0;
        end else if (vld) begin
            seg_max <= max_nxt;
            seg_min <= min_nxt;
        end
    end

    AST_MAX_GE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        seg_max >= seg_min); // R4
endmodule

// File: rtl/ecg_baseline.sv
// Baseline estimator: a moving average over 2^AVG_LOG2 accepted samples,
// built from a tap chain and a running sum. It reports how far the estimate
// moved inside the current segment (maximum minus minimum). The average runs
// across segment boundaries; only the span restarts on 'first'.
module ecg_baseline #(
    parameter int W        = 11,
    parameter int AVG_LOG2 = 5,
    localparam int N       = 1 << AVG_LOG2,
    localparam int SW      = W + AVG_LOG2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vld,
    input  logic                first,
    input  logic signed [W-1:0] x,
    output logic [W:0]          span_nxt
);
    logic signed [SW-1:0] sum, sum_nxt, sum_sh;
    logic signed [W-1:0]  avg_nxt, oldest;
    logic signed [W-1:0]  bmax, bmin, bmax_nxt, bmin_nxt;

    // Tap chain holding the last N accepted samples.
    for (genvar k = 0; k < N; k++) begin : g_tap
        logic signed [W-1:0] q;
        if (k == 0) begin : g_head
            // First tap takes the incoming sample.
            always_ff @(posedge clk) begin
                if (!rst_n)   q <= '0;
                else if (vld) q <= x;
            end
        end else begin : g_body
            // Later taps shift from their neighbour.
            always_ff @(posedge clk) begin
                if (!rst_n)   q <= '0;
                else if (vld) q <= g_tap[k-1].q;
            end
        end
    end
    assign oldest = g_tap[N-1].q;

    // Running sum, floored mean and the baseline span in this segment.
    always_comb begin
        sum_nxt  = sum + SW'(x) - SW'(oldest);
        sum_sh   = sum_nxt >>> AVG_LOG2;
        avg_nxt  = sum_sh[W-1:0];
        if (first) begin
            bmax_nxt = avg_nxt;
            bmin_nxt = avg_nxt;
        end else begin
            bmax_nxt = (avg_nxt > bmax) ? avg_nxt : bmax;
            bmin_nxt = (avg_nxt < bmin) ? avg_nxt : bmin;
        end
        span_nxt = {bmax_nxt[W-1], bmax_nxt} - {bmin_nxt[W-1], bmin_nxt};
    end

    // Sum and baseline extremes update on accepted samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum  <= '0;
            bmax <= '0;
            bmin <= '0;
        end else if (vld) begin
            sum  <= sum_nxt;
            bmax <= bmax_nxt;
            bmin <= bmin_nxt;
        end
    end

    AST_BASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        bmax >= bmin); // R5
endmodule

// File: rtl/ecg_seg_quality.sv
// Segment quality grader, top level.
// Counts accepted samples into segments of SEG_LEN, collects statistics from
// the turning-point tracker, the extreme tracker and the baseline estimator,
// and on the last sample of a segment registers the flags, index and grade.
// Assumes: SEG_LEN >= 2; thresholds INT_BP/BAD_BP are in units of 0.01 %.
module ecg_seg_quality #(
    parameter int W         = 11,
    parameter int SEG_LEN   = 360,
    parameter int AVG_LOG2  = 5,
    parameter int FS_UV     = 10000,
    parameter int ABW_UV    = 200,
    parameter int FLAT_P2P  = 16,
    parameter int HF_TP_PCT = 5,
    parameter int INT_BP    = 5,
    parameter int BAD_BP    = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp_vld,
    input  logic [W-1:0] smp_data,
    output logic         seg_done,
    output logic         flag_absent,
    output logic         flag_wander,
    output logic         flag_hfnoise,
    output logic [1:0]   sqi,
    output logic [1:0]   grade
);
    import ecg_sq_pkg::*;

    localparam int CW        = $clog2(SEG_LEN + 1);
    localparam int IW        = $clog2(SEG_LEN);
    localparam int MW        = 48;
    localparam int ABW_CODES = (ABW_UV * (1 << W)) / FS_UV;

    logic signed [W-1:0] x;
    logic [IW-1:0]       seg_idx;
    logic                first, last;
    logic [CW-1:0]       tp_cnt_nxt;
    logic                short_nxt;
    logic [W:0]          amp_nxt, span_nxt;
    logic signed [W-1:0] max_nxt, min_nxt;

    logic [W:0]          p2p, abs_max, abs_min, ext;
    logic                flat_c, r1_c, hf_c, abw_c;
    logic [MW-1:0]       amp_sc, bad_lim, mid_lim;
    grade_e              grade_c;

    assign x     = smp_data;
    assign first = (seg_idx == '0);
    assign last  = (seg_idx == IW'(SEG_LEN - 1));

    // Segment position counter, advancing on accepted samples only.
    always_ff @(posedge clk) begin
        if (!rst_n)       seg_idx <= '0;
        else if (smp_vld) seg_idx <= last ? '0 : seg_idx + 1'b1;
    end

    ecg_tp_track #(.W(W), .SEG_LEN(SEG_LEN)) tp_i (
        .clk(clk), .rst_n(rst_n), .vld(smp_vld), .first(first), .x(x),
        .tp_cnt_nxt(tp_cnt_nxt), .short_nxt(short_nxt), .amp_nxt(amp_nxt));

    ecg_amp_span #(.W(W)) span_i (
        .clk(clk), .rst_n(rst_n), .vld(smp_vld), .first(first), .x(x),
        .max_nxt(max_nxt), .min_nxt(min_nxt));

    ecg_baseline #(.W(W), .AVG_LOG2(AVG_LOG2)) base_i (
        .clk(clk), .rst_n(rst_n), .vld(smp_vld), .first(first), .x(x),
        .span_nxt(span_nxt));

    // Segment decision rules: flat, wander, noise, then grade.
    always_comb begin
        p2p     = {max_nxt[W-1], max_nxt} - {min_nxt[W-1], min_nxt};
        abs_max = max_nxt[W-1] ? (W+1)'(-{max_nxt[W-1], max_nxt}) : (W+1)'({1'b0, max_nxt});
        abs_min = min_nxt[W-1] ? (W+1)'(-{min_nxt[W-1], min_nxt}) : (W+1)'({1'b0, min_nxt});
        ext     = (abs_max > abs_min) ? abs_max : abs_min;

        flat_c  = (tp_cnt_nxt == '0) || (p2p < (W+1)'(FLAT_P2P));
        r1_c    = (MW'(tp_cnt_nxt) * MW'(100)) > (MW'(HF_TP_PCT) * MW'(SEG_LEN));
        hf_c    = !flat_c && r1_c && short_nxt;
        abw_c   = span_nxt > (W+1)'(ABW_CODES);

        amp_sc  = MW'(amp_nxt) * MW'(10000);
        bad_lim = MW'(BAD_BP) * MW'(ext);
        mid_lim = MW'(INT_BP) * MW'(ext);

        if (flat_c || abw_c)      grade_c = GRADE_BAD;
        else if (!hf_c)           grade_c = GRADE_GOOD;
        else if (amp_sc > bad_lim) grade_c = GRADE_BAD;
        else if (amp_sc > mid_lim) grade_c = GRADE_MID;
        else                      grade_c = GRADE_GOOD;
    end

    // Output registers: loaded on the last sample, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_done     <= 1'b0;
            flag_absent  <= 1'b0;
            flag_wander  <= 1'b0;
            flag_hfnoise <= 1'b0;
            sqi          <= '0;
            grade        <= GRADE_GOOD;
        end else begin
            seg_done <= smp_vld && last;
            if (smp_vld && last) begin
                flag_absent  <= flat_c;
                flag_wander  <= abw_c;
                flag_hfnoise <= hf_c;
                sqi          <= 2'(flat_c) + 2'(abw_c) + 2'(hf_c);
                grade        <= grade_c;
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        seg_done |=> !seg_done); // R1
    AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> !seg_done); // R1
    AST_FLAT_BLOCKS_HF: assert property (@(posedge clk) disable iff (!rst_n)
        flag_absent |-> !flag_hfnoise); // R4
    AST_GRADE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        grade != 2'b11); // R7
    AST_UNACCEPT_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_absent || flag_wander) |-> (grade == GRADE_BAD)); // R7
    AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({flag_absent, flag_wander, flag_hfnoise, sqi, grade}) |-> seg_done); // R8
endmodule

// File: tb/ecg_seg_quality_tb.sv
`timescale 1ns/1ps
module ecg_seg_quality_tb_top;
    localparam int W    = 11;
    localparam int SEG  = 40;
    localparam int AL2  = 5;
    localparam int NAVG = 1 << AL2;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         smp_vld;
    logic [W-1:0] smp_data;
    logic         seg_done, flag_absent, flag_wander, flag_hfnoise;
    logic [1:0]   sqi, grade;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    int sbuf [SEG];
    int hist [NAVG];
    int e_flat, e_abw, e_hf, e_sqi, e_grade;

    always #2 clk = ~clk;

    ecg_seg_quality #(
        .W(W), .SEG_LEN(SEG), .AVG_LOG2(AL2), .FS_UV(10000), .ABW_UV(200),
        .FLAT_P2P(8), .HF_TP_PCT(5), .INT_BP(1000), .BAD_BP(2000)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
        .seg_done(seg_done), .flag_absent(flag_absent), .flag_wander(flag_wander),
        .flag_hfnoise(flag_hfnoise), .sqi(sqi), .grade(grade));

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected result of the segment in sbuf, from the requirements.
    task automatic model_segment();
        int tp = 0, gap = 0, amp = 0, mx, mn, bmax = 0, bmin = 0, ext, p2p;
        bit have_sgn = 0, up = 0, have_tp = 0, shrt = 0, r1;
        mx = sbuf[0];
        mn = sbuf[0];
        for (int i = 0; i < SEG; i++) begin
            int sum = 0, avg;
            for (int k = NAVG - 1; k > 0; k--) hist[k] = hist[k-1];
            hist[0] = sbuf[i];
            for (int k = 0; k < NAVG; k++) sum += hist[k];
            avg = sum >>> AL2;
            if (i == 0) begin bmax = avg; bmin = avg; end
            else begin
                if (avg > bmax) bmax = avg;
                if (avg < bmin) bmin = avg;
            end
            if (sbuf[i] > mx) mx = sbuf[i];
            if (sbuf[i] < mn) mn = sbuf[i];
            if (i > 0) begin
                int d = sbuf[i] - sbuf[i-1];
                bit upn = (d > 0);
                if (have_sgn && d != 0 && upn != up) begin
                    if (have_tp && gap == 0) begin
                        shrt = 1;
                        if ((d < 0 ? -d : d) > amp) amp = (d < 0 ? -d : d);
                    end
                    tp++;
                    have_tp = 1;
                    gap = 0;
                end else gap++;
                if (d != 0) begin have_sgn = 1; up = upn; end
            end
        end
        p2p    = mx - mn;
        ext    = ((mx < 0 ? -mx : mx) > (mn < 0 ? -mn : mn)) ? (mx < 0 ? -mx : mx) : (mn < 0 ? -mn : mn);
        e_flat = (tp == 0 || p2p < 8) ? 1 : 0;
        r1     = (tp * 100) > (5 * SEG);
        e_hf   = (!e_flat && r1 && shrt) ? 1 : 0;
        e_abw  = ((bmax - bmin) > 40) ? 1 : 0;
        e_sqi  = e_flat + e_abw + e_hf;
        if (e_flat || e_abw) e_grade = 2;
        else if (!e_hf) e_grade = 0;
        else if (longint'(amp) * 10000 > longint'(2000) * ext) e_grade = 2;
        else if (longint'(amp) * 10000 > longint'(1000) * ext) e_grade = 1;
        else e_grade = 0;
    endtask

    // Drive sbuf as one segment (with optional idle cycles) and check it.
    task automatic run_segment(string tag, int idle);
        model_segment();
        for (int i = 0; i < SEG; i++) begin
            if (idle > 0 && (i % 3) == 1) begin
                for (int j = 0; j < idle; j++) begin
                    @(negedge clk);
                    smp_vld = 1'b0;
                    smp_data = W'(12345);
                    if (j > 0) chk("R1", {tag, " no done in idle"}, int'(seg_done), 0);
                end
            end
            @(negedge clk);
            smp_vld  = 1'b1;
            smp_data = W'(sbuf[i]);
            if (i > 0) chk("R1", {tag, " no early done"}, int'(seg_done), 0);
        end
        @(negedge clk);
        smp_vld = 1'b0;
        chk("R1", {tag, " done pulse"}, int'(seg_done), 1);
        chk("R4", {tag, " flat"}, int'(flag_absent), e_flat);
        chk("R5", {tag, " wander"}, int'(flag_wander), e_abw);
        chk("R3", {tag, " hf"}, int'(flag_hfnoise), e_hf);
        chk("R6", {tag, " sqi"}, int'(sqi), e_sqi);
        chk("R7", {tag, " grade"}, int'(grade), e_grade);
        repeat (2) @(negedge clk);
        chk("R1", {tag, " done one cycle"}, int'(seg_done), 0);
        chk("R8", {tag, " grade held"}, int'(grade), e_grade);
        chk("R8", {tag, " sqi held"}, int'(sqi), e_sqi);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; smp_vld = 1'b0; smp_data = '0;
        for (int k = 0; k < NAVG; k++) hist[k] = 0;
        repeat (3) @(negedge clk);
        chk("R8", "reset done", int'(seg_done), 0);
        chk("R8", "reset flags", int'({flag_absent, flag_wander, flag_hfnoise}), 0);
        chk("R8", "reset sqi", int'(sqi), 0);
        chk("R8", "reset grade", int'(grade), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_clean();
        for (int i = 0; i < SEG; i++) begin
            int ph = i % 16;
            sbuf[i] = 400 + (ph < 8 ? 8 - ph : ph - 8) * 10 - 40;
        end
        run_segment("clean settle", 0);
        run_segment("clean", 0);
        chk("R2", "clean tp rule alone not noise", int'(flag_hfnoise), 0);
        chk("R7", "clean good", int'(grade), 0);
    endtask

    task automatic t_zigzag(int e, int want, int idle, string tag);
        for (int i = 0; i < SEG; i++) sbuf[i] = 400 + ((i % 2) ? -e : e);
        run_segment({tag, " settle"}, idle);
        run_segment(tag, idle);
        chk("R3", {tag, " noisy"}, int'(flag_hfnoise), 1);
        chk("R7", {tag, " band"}, int'(grade), want);
    endtask

    task automatic t_flat();
        for (int i = 0; i < SEG; i++) sbuf[i] = 400;
        run_segment("flat", 0);
        chk("R4", "constant is flat", int'(flag_absent), 1);
    endtask

    task automatic t_tiny();
        for (int i = 0; i < SEG; i++) sbuf[i] = 400 + ((i % 2) ? -3 : 3);
        run_segment("tiny settle", 0);
        run_segment("tiny", 0);
        chk("R4", "small p2p flat", int'(flag_absent), 1);
        chk("R4", "flat suppresses hf", int'(flag_hfnoise), 0);
    endtask

    task automatic t_wander();
        for (int i = 0; i < SEG; i++) sbuf[i] = (i < 20 ? 400 : 700) + ((i % 2) ? -20 : 20);
        run_segment("wander", 0);
        chk("R5", "step wander", int'(flag_wander), 1);
        chk("R6", "wander plus noise sqi", int'(sqi), 2);
    endtask

    task automatic t_fresh();
        for (int i = 0; i < SEG; i++) sbuf[i] = -200 + 10 * i;
        run_segment("ramp up", 0);
        for (int i = 0; i < SEG; i++) sbuf[i] = 180 - 10 * i;
        run_segment("ramp down", 0);
        chk("R9", "reversal at boundary not counted", int'(flag_absent), 1);
    endtask

    initial begin
        t_reset();
        t_clean();
        t_zigzag(5, 0, 0, "zig5");
        t_zigzag(30, 1, 0, "zig30");
        t_zigzag(60, 2, 0, "zig60");
        t_flat();
        t_tiny();
        t_wander();
        t_zigzag(30, 1, 2, "gaps30");
        t_fresh();
        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #800000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule